// File: doc/BRIEF.md
# Memory-Copy Descriptor Pair Generator

This block turns one memory-copy request into the descriptors a scatter-gather copy engine fetches. A request gives a source address, a destination address, a byte count, an ordering mode, an architecture level and an interrupt flag. The block emits one or more descriptor pairs. The receive half of each pair carries the destination address and goes out on the receive stream. The transmit half carries the source address and goes out on the transmit stream. Both halves belong to the same queue.

One descriptor moves at most 65536 bytes, so larger copies become a chain of pairs. The chain is marked first, continuation and last. The ring phase is inserted into every descriptor. The ordering bits go only on the final pair, in the word and direction that the mode selects. The block rejects a request when its mode is not supported on the requested architecture level, when the chain is longer than one packet may hold, or when the byte count is zero. A rejected request emits nothing.

Each descriptor is a single beat that holds three fields: the control word (offset 0), the meta-control word (offset 4) and the 64-bit buffer address (offset 8). The receive half of a pair is always presented and accepted before its transmit half. The next pair starts only after that transmit half has been taken.

Top module: `copy_pair_gen`

## Requirements
- R1: For every pair, the receive descriptor is accepted before the transmit descriptor is presented. `rx_valid` and `tx_valid` are never high together. A presented descriptor holds its value until it is accepted.
- R2: Pair k of a request (k counted from 0) carries the address dst+65536·k on the receive side and src+65536·k on the transmit side.
- R3: Control bits [15:0] hold the byte count of the chunk. Every pair except the last carries 65536 bytes, encoded as 0. The last pair carries the rest of the count, and a rest of exactly 65536 is also encoded as 0. Bits [23:16] are zero.
- R4: Control bit 26 (first) is set only on the first pair. Bit 27 (last) is set only on the final pair. Bit 31 (continuation) is set on every pair except the first. A single-pair request therefore carries both first and last.
- R5: The receive meta-control word is 0. The transmit meta-control word is 0x01080003, with bit 26 added on the final pair when the mode is write-barrier.
- R6: The ordering mode is coded 0 = none, 1 = data memory barrier, 2 = write barrier, 3 = strong-ordered write. On the final pair only, mode 1 sets transmit control bit 30 and mode 3 sets receive control bit 29. No other pair and no other mode sets bit 29 or bit 30.
- R7: When the interrupt flag is set, receive control bit 28 is set on the final pair only. Transmit control bit 28 is never set.
- R8: Control bits [25:24] carry the ring phase. Both halves of a pair carry the same phase. The phase is 1 after reset and advances by one, modulo 4, after every RING_DEPTH pairs.
- R9: Mode 3 together with an architecture level of 2 or below is rejected. `err` is high for the one cycle after the request is accepted, and no descriptor is emitted for that request.
- R10: A request is also rejected in the same way when its byte count is 0, or when its chain is longer than 128 pairs (level 2 or below) or 65 pairs (level 3 or above). A chain of exactly 128 or 65 pairs is accepted.
- R11: `req_ready` is high exactly when no pair of an earlier request is still outstanding. After reset, `req_ready` is 1 and `rx_valid`, `tx_valid` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_src | input | AW | Source physical address |
| req_dst | input | AW | Destination physical address |
| req_size | input | SW | Byte count |
| req_order | input | 2 | Ordering mode (0 none, 1 data memory barrier, 2 write barrier, 3 strong-ordered write) |
| req_arch | input | 3 | Architecture level |
| req_irq | input | 1 | Request an interrupt on completion of the final pair |
| err | output | 1 | One-cycle pulse for a rejected request |
| rx_valid | output | 1 | Receive descriptor present |
| rx_ready | input | 1 | Receive descriptor taken |
| rx_ctrl | output | 32 | Receive control word |
| rx_meta | output | 32 | Receive meta-control word |
| rx_addr | output | AW | Receive buffer (destination) address |
| tx_valid | output | 1 | Transmit descriptor present |
| tx_ready | input | 1 | Transmit descriptor taken |
| tx_ctrl | output | 32 | Transmit control word |
| tx_meta | output | 32 | Transmit meta-control word |
| tx_addr | output | AW | Transmit buffer (source) address |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover:
- the exclusive and ordered receive-then-transmit handshake, and the holding of a stalled descriptor;
- the fixed meta-control values;
- the absence of interrupt and strong-order bits on the transmit side;
- equal phase across the two halves of a pair;
- quiet streams while the block is idle or reporting an error.

Other behaviour depends on the request as a whole, and only the bench's scenarios can show it. This covers:
- chunk lengths and the zero-means-65536 encoding;
- address stepping along a chain;
- the first, continuation and last marking;
- the placement of the ordering bits on the final pair;
- phase wrap across many pairs;
- the exact chain-length limits for each architecture level.

The bench's behavioural model predicts every beat, including under random back-pressure.

// File: rtl/copy_pair_gen.sv
module copy_pair_gen #(
  parameter int AW         = 64,
  parameter int SW         = 32,
  parameter int RING_DEPTH = 16,
  parameter int MAX_OLD    = 128,
  parameter int MAX_NEW    = 65,
  parameter int OLD_LEVEL  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic [SW-1:0] req_size,
  input  logic [1:0]    req_order,
  input  logic [2:0]    req_arch,
  input  logic          req_irq,
  output logic          err,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [31:0]   rx_ctrl,
  output logic [31:0]   rx_meta,
  output logic [AW-1:0] rx_addr,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [31:0]   tx_ctrl,
  output logic [31:0]   tx_meta,
  output logic [AW-1:0] tx_addr
);
  localparam int CHUNK = 65536;
  localparam int NW    = SW - 15;
  localparam int IW    = $clog2(RING_DEPTH);
  localparam logic [1:0] S_IDLE = 2'd0, S_RX = 2'd1, S_TX = 2'd2;

  logic [1:0]    st;
  logic [SW-1:0] rem;
  logic [AW-1:0] src_q, dst_q;
  logic          first_q, irq_q;
  logic [1:0]    ord_q;
  logic [IW-1:0] slot;
  logic [1:0]    phase;

  wire [NW-1:0] nchunks = NW'(({1'b0, req_size} + (SW+1)'(CHUNK - 1)) >> 16);
  wire          old_arch = req_arch <= 3'(OLD_LEVEL);
  wire [NW-1:0] limit = old_arch ? NW'(MAX_OLD) : NW'(MAX_NEW);
  wire          reject = (req_size == '0) || (old_arch && req_order == 2'd3) || (nchunks > limit);

  wire        last = rem <= SW'(CHUNK);
  wire [15:0] len  = last ? rem[15:0] : 16'h0000;
  wire [31:0] base_ctrl = {~first_q, 3'b000, last, first_q, phase, 8'h00, len};

  assign req_ready = st == S_IDLE;
  assign rx_valid  = st == S_RX;
  assign tx_valid  = st == S_TX;
  assign rx_addr   = dst_q;
  assign tx_addr   = src_q;
  assign rx_meta   = 32'h0;
  assign rx_ctrl   = base_ctrl | {2'b00, last && ord_q == 2'd3, last && irq_q, 28'h0};
  assign tx_ctrl   = base_ctrl | {1'b0, last && ord_q == 2'd1, 30'h0};
  assign tx_meta   = 32'h0108_0003 | {5'b0, last && ord_q == 2'd2, 26'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      err     <= 1'b0;
      rem     <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      first_q <= 1'b0;
      irq_q   <= 1'b0;
      ord_q   <= 2'd0;
      slot    <= '0;
      phase   <= 2'd1;
    end else begin
      err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (reject) err <= 1'b1;
          else begin
            rem     <= req_size;
            src_q   <= req_src;
            dst_q   <= req_dst;
            first_q <= 1'b1;
            irq_q   <= req_irq;
            ord_q   <= req_order;
            st      <= S_RX;
          end
        end
        S_RX: if (rx_ready) st <= S_TX;
        S_TX: if (tx_ready) begin
          if (slot == IW'(RING_DEPTH - 1)) begin
            slot  <= '0;
            phase <= phase + 2'd1;
          end else slot <= slot + 1'b1;
          if (last) st <= S_IDLE;
          else begin
            rem     <= rem - SW'(CHUNK);
            src_q   <= src_q + AW'(CHUNK);
            dst_q   <= dst_q + AW'(CHUNK);
            first_q <= 1'b0;
            st      <= S_RX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/copy_pair_gen_chk.sv
module copy_pair_gen_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          err,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [31:0]   rx_ctrl,
  input logic [31:0]   rx_meta,
  input logic [AW-1:0] rx_addr,
  input logic          tx_valid,
  input logic [31:0]   tx_ctrl,
  input logic [31:0]   tx_meta
);
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_valid)); // R1
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_addr) && $stable(rx_ctrl)); // R1
  AST_TX_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(rx_valid && rx_ready)); // R1
  AST_RX_META_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_meta == 32'h0); // R5
  AST_TX_META_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_meta & ~32'h0400_0000) == 32'h0108_0003); // R5
  AST_TX_NO_RX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_ctrl[29] && !tx_ctrl[28]); // R6
  AST_PAIR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_ctrl[25:24] == $past(rx_ctrl[25:24])); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rx_valid && !tx_valid); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rx_valid && !tx_valid); // R11
endmodule

bind copy_pair_gen copy_pair_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .err(err),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ctrl(rx_ctrl), .rx_meta(rx_meta),
  .rx_addr(rx_addr), .tx_valid(tx_valid), .tx_ctrl(tx_ctrl), .tx_meta(tx_meta)
);

// File: tb/copy_pair_gen_tb.sv
`timescale 1ns/1ps
module copy_pair_gen_tb;
  localparam int DEPTH = 16;
  localparam longint CH = 65536;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_irq = 1'b0, err;
  logic [63:0] req_src = '0, req_dst = '0;
  logic [31:0] req_size = '0;
  logic [1:0] req_order = '0;
  logic [2:0] req_arch = '0;
  logic rx_valid, rx_ready = 1'b0, tx_valid, tx_ready = 1'b0;
  logic [31:0] rx_ctrl, rx_meta, tx_ctrl, tx_meta;
  logic [63:0] rx_addr, tx_addr;

  always #2.5 clk = ~clk;

  copy_pair_gen #(.RING_DEPTH(DEPTH)) u_dut (.*);

  typedef struct { longint unsigned src, dst, size; int ord, arch; bit irq; } req_t;
  typedef struct { bit is_rx; logic [31:0] ctrl, meta; logic [63:0] addr; } beat_t;
  req_t reqs[$];
  beat_t expq[$];
  int checks = 0, errors = 0, pairs = 0, ri = 0;
  bit pend_err = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add(input longint unsigned s, d, sz, input int o, a, input bit i);
    req_t r;
    r.src = s; r.dst = d; r.size = sz; r.ord = o; r.arch = a; r.irq = i;
    reqs.push_back(r);
  endtask

  task automatic model_accept(input req_t r);
    longint unsigned n;
    int lim;
    n = (r.size + CH - 1) / CH;
    lim = (r.arch <= 2) ? 128 : 65;
    if (r.size == 0 || n > lim || (r.ord == 3 && r.arch <= 2)) begin
      pend_err = 1;
      return;
    end
    for (longint unsigned k = 0; k < n; k++) begin
      beat_t b;
      bit lst, fst;
      logic [31:0] c;
      longint unsigned chunk;
      lst = (k == n - 1);
      fst = (k == 0);
      chunk = lst ? r.size - k * CH : CH;
      c = 32'(chunk % CH) | (32'((1 + pairs / DEPTH) % 4) << 24)
        | (32'(fst) << 26) | (32'(lst) << 27) | (32'(!fst) << 31);
      pairs++;
      b.is_rx = 1; b.meta = 0; b.addr = r.dst + k * CH;
      b.ctrl = c | (32'(lst && r.ord == 3) << 29) | (32'(lst && r.irq) << 28);
      expq.push_back(b);
      b.is_rx = 0; b.addr = r.src + k * CH;
      b.ctrl = c | (32'(lst && r.ord == 1) << 30);
      b.meta = 32'h0108_0003 | (32'(lst && r.ord == 2) << 26);
      expq.push_back(b);
    end
  endtask

  task automatic cmp_beat(input beat_t e, input logic [31:0] c, m, input logic [63:0] a);
    chk(a == e.addr, "R2 address", a, e.addr);
    chk(c[23:0] == e.ctrl[23:0] && c[15:0] == e.ctrl[15:0], "R3 length", {40'h0, c[23:0]}, {40'h0, e.ctrl[23:0]});
    chk(c[25:24] == e.ctrl[25:24], "R8 phase", c[25:24], e.ctrl[25:24]);
    chk({c[31], c[27:26]} == {e.ctrl[31], e.ctrl[27:26]}, "R4 chain flags", {c[31], c[27:26]}, {e.ctrl[31], e.ctrl[27:26]});
    chk(c[30:29] == e.ctrl[30:29], "R6 ordering bits", c[30:29], e.ctrl[30:29]);
    chk(c[28] == e.ctrl[28], "R7 interrupt bit", c[28], e.ctrl[28]);
    chk(m == e.meta, "R5 meta word", m, e.meta);
  endtask

  task automatic step();
    chk(err == pend_err, pend_err ? "R9/R10 reject pulse" : "R9 spurious err", err, pend_err);
    pend_err = 0;
    chk(req_ready == (expq.size() == 0), "R11 req_ready", req_ready, expq.size() == 0);
    if (expq.size() == 0) begin
      chk(!rx_valid && !tx_valid, "R1 idle streams", {rx_valid, tx_valid}, 0);
    end else if (expq[0].is_rx) begin
      chk(rx_valid && !tx_valid, "R1 receive first", {rx_valid, tx_valid}, 2'b10);
      if (rx_valid) cmp_beat(expq[0], rx_ctrl, rx_meta, rx_addr);
    end else begin
      chk(tx_valid && !rx_valid, "R1 transmit second", {rx_valid, tx_valid}, 2'b01);
      if (tx_valid) cmp_beat(expq[0], tx_ctrl, tx_meta, tx_addr);
    end
    rx_ready = ($urandom % 4) != 0;
    tx_ready = ($urandom % 4) != 0;
    req_valid = ri < reqs.size();
    if (req_valid) begin
      req_src = reqs[ri].src; req_dst = reqs[ri].dst; req_size = 32'(reqs[ri].size);
      req_order = 2'(reqs[ri].ord); req_arch = 3'(reqs[ri].arch); req_irq = reqs[ri].irq;
    end
    if (expq.size() != 0 && ((expq[0].is_rx && rx_valid && rx_ready) || (!expq[0].is_rx && tx_valid && tx_ready)))
      void'(expq.pop_front());
    else if (req_valid && req_ready) begin
      model_accept(reqs[ri]);
      ri++;
    end
  endtask

  initial begin
    add(64'h1000, 64'h8000_0000, 100, 0, 3, 0);
    add(64'h2_0000, 64'h9_0000, 65536, 1, 2, 0);
    add(64'hA0_0000, 64'hB0_0000, 65537, 2, 3, 1);
    add(64'hFFFF_FFFF_FFFF_0000, 64'h40_0000, 3 * 65536 + 5, 3, 3, 1);
    add(64'h10, 64'h20, 10, 3, 2, 0);
    add(64'h10, 64'h20, 10, 3, 1, 1);
    add(64'h10, 64'h20, 0, 0, 4, 0);
    add(64'h100_0000, 64'h200_0000, 128 * 65536, 0, 2, 0);
    add(64'h100_0000, 64'h200_0000, 128 * 65536 + 1, 0, 2, 0);
    add(64'h300_0000, 64'h400_0000, 65 * 65536, 1, 3, 1);
    add(64'h300_0000, 64'h400_0000, 65 * 65536 + 1, 0, 4, 0);
    add(64'h77, 64'h99, 3, 2, 5, 1);
    for (int i = 0; i < 24; i++)
      add({$urandom, $urandom}, {$urandom, $urandom}, 1 + ($urandom % (5 * 65536)),
          $urandom % 4, 1 + ($urandom % 6), 1'($urandom));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rx_valid && !tx_valid && !err, "R11 reset state",
        {req_ready, rx_valid, tx_valid, err}, 4'b1000);
    rst_n = 1'b1;
    while (ri < reqs.size() || expq.size() != 0 || pend_err) begin
      @(negedge clk);
      step();
    end
    @(negedge clk);
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", ri, reqs.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule